// File: doc/BRIEF.md
# Sequenced Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words (1 sign bit, 8 biased exponent bits, 23 fraction bits) through a fixed four-step sequence. The steps are: form the significand product, normalize it, classify the exponent, and pack the result. A supervising controller raises `start` with the operands applied. The block captures the operands on the edge where it accepts them. Four edges later it raises `done`, with the product and the overflow flag valid.

The exchange is a four-phase handshake. `done` stays high, and the outputs stay frozen, for as long as `start` stays high. The block returns to idle only after `start` falls. This means a result that is ready early can be neither missed nor double-counted.

An operand whose exponent field is zero counts as zero, so denormals are flushed. Rounding is truncation. The exponent arithmetic is kept wide, so results that are too large or too small are detected rather than wrapped. A result that is too large saturates and raises the flag. A result that is too small flushes to zero.

Top module: `fpmul_seq`

## Requirements
- R1: While and immediately after reset, `done` is 0, `overflow` is 0 and `product` is all zeros.
- R2: Bit 31 of the product is the XOR of bit 31 of the two captured operands, in every case, including zero, overflow and underflow results.
- R3: For normal operands, the fraction field (bits 22:0) is built from the 48-bit product of the two 24-bit significands (hidden one restored). If product bit 47 is 1, the field is product bits 46:24. Otherwise it is bits 45:23. Lower bits are dropped (truncation).
- R4: The result exponent field (bits 30:23) equals exponent A plus exponent B minus 127, plus 1 when product bit 47 is set.
- R5: When `start` is high in idle, the operands are accepted on that clock edge. `done` is first seen high after the fourth following edge.
- R6: While `done` and `start` are both high, `done`, `product` and `overflow` hold. The first edge that sees `start` low while `done` is high returns the block to idle, and `done` falls.
- R7: Changes on `op_a` or `op_b` after the accepting edge do not affect the result. A `start` that falls during the sequence does not stop it.
- R8: If either operand has exponent field 0, the result is a zero with the R2 sign, and `overflow` is 0.
- R9: If the R4 exponent exceeds 254, `overflow` is 1 and the result is the signed largest finite value: exponent field 254 and fraction all ones.
- R10: If the R4 exponent is below 1, the result is a zero with the R2 sign, and `overflow` is 0.
- R11: `product` and `overflow` keep their values after `done` falls, until the next sequence completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request from the controller; held high until `done` is seen |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| product | output | 32 | Packed result |
| done | output | 1 | Result valid; high until `start` falls |
| overflow | output | 1 | Result exponent exceeded the representable range |

## Verification
The hardest situations to reach from the ports are the exponent boundaries where the normalization increment decides the outcome. In one, a product that would underflow is lifted into the smallest normal exponent. In the other, a product at the largest exponent is pushed into overflow. The stimulus table pairs operands whose biased exponents sum to exactly those edges, using significands of 1.5 so that product bit 47 is set. Separate directed runs cover the handshake timing: one changes the operands while the sequence is running, and one pulses `start` for a single cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Sequencer states: one per arithmetic step, plus idle and handshake hold.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MUL   = 3'd1,
    ST_NORM  = 3'd2,
    ST_CLASS = 3'd3,
    ST_PACK  = 3'd4,
    ST_DONE  = 3'd5
  } fpm_state_e;

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output fpm_state_e state_o,
  output logic       accept_o,
  output logic       mul_en_o,
  output logic       norm_en_o,
  output logic       cls_en_o,
  output logic       pack_en_o,
  output logic       done_o
);

  fpm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_MUL;
      ST_MUL:   state_d = ST_NORM;
      ST_NORM:  state_d = ST_CLASS;
      ST_CLASS: state_d = ST_PACK;
      ST_PACK:  state_d = ST_DONE;
      ST_DONE:  if (!start) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Step strobes brought out as named wires for the datapath and the checks.
  assign accept_o  = (state_q == ST_IDLE) && start;
  assign mul_en_o  = (state_q == ST_MUL);
  assign norm_en_o = (state_q == ST_NORM);
  assign cls_en_o  = (state_q == ST_CLASS);
  assign pack_en_o = (state_q == ST_PACK);
  assign done_o    = (state_q == ST_DONE);
  assign state_o   = state_q;

  // R5: at most one arithmetic step is active in any cycle.
  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept_o, mul_en_o, norm_en_o, cls_en_o, pack_en_o, done_o}));

  // R6: done with start still high keeps the block in the hold state.
  a_r6_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start) |=> done_o);

  // R6: done with start low returns to idle on the next edge.
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start) |=> (state_o == ST_IDLE));

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             mul_en,
  input  logic             norm_en,
  input  logic             cls_en,
  input  logic             pack_en,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic [EXP_W+FRAC_W:0] result_o,
  output logic             ovf_o
);

  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EW     = EXP_W + 2;
  localparam logic signed [EW-1:0] BIAS_S = EW'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [EW-1:0] EMAX_S = EW'((1 << EXP_W) - 2);
  localparam logic signed [EW-1:0] EMIN_S = EW'(1);
  localparam logic [EXP_W-1:0]  EMAX_F = {{(EXP_W-1){1'b1}}, 1'b0};

  // ---------------- arithmetic helpers ----------------
  function automatic logic [EXP_W-1:0] f_exp(input logic [W-1:0] w);
    return w[W-2 -: EXP_W];
  endfunction

  function automatic logic [SIG_W-1:0] f_sig(input logic [W-1:0] w);
    return {1'b1, w[FRAC_W-1:0]};
  endfunction

  function automatic logic f_is_zero(input logic [W-1:0] w);
    return (f_exp(w) == '0);
  endfunction

  function automatic logic signed [EW-1:0] f_exp_sum(input logic [EXP_W-1:0] ea,
                                                     input logic [EXP_W-1:0] eb);
    return $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS_S;
  endfunction

  function automatic logic [FRAC_W-1:0] f_norm_frac(input logic [PROD_W-1:0] p);
    return p[PROD_W-1] ? p[PROD_W-2 -: FRAC_W] : p[PROD_W-3 -: FRAC_W];
  endfunction

  function automatic logic signed [EW-1:0] f_norm_exp(input logic signed [EW-1:0] e,
                                                      input logic [PROD_W-1:0] p);
    return e + $signed({{(EW-1){1'b0}}, p[PROD_W-1]});
  endfunction

  // ---------------- stage registers ----------------
  logic [W-1:0]            a_q, b_q;
  logic [PROD_W-1:0]       prod_q;
  logic                    sgn_q, zero_q;
  logic signed [EW-1:0]    esum_q, enorm_q;
  logic [FRAC_W-1:0]       frac_q;
  logic                    big_q, small_q;
  logic [W-1:0]            result_q;
  logic                    ovf_q;

  // Named events for the checks.
  logic exp_too_big, exp_too_small;
  assign exp_too_big   = (enorm_q > EMAX_S);
  assign exp_too_small = (enorm_q < EMIN_S);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (cap_en) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  // Step 1: significand product, sign, raw exponent, zero detect.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      sgn_q  <= 1'b0;
      zero_q <= 1'b0;
      esum_q <= '0;
    end else if (mul_en) begin
      prod_q <= {{SIG_W{1'b0}}, f_sig(a_q)} * {{SIG_W{1'b0}}, f_sig(b_q)};
      sgn_q  <= a_q[W-1] ^ b_q[W-1];
      zero_q <= f_is_zero(a_q) || f_is_zero(b_q);
      esum_q <= f_exp_sum(f_exp(a_q), f_exp(b_q));
    end
  end

  // Step 2: normalize.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q  <= '0;
      enorm_q <= '0;
    end else if (norm_en) begin
      frac_q  <= f_norm_frac(prod_q);
      enorm_q <= f_norm_exp(esum_q, prod_q);
    end
  end

  // Step 3: classify the exponent range.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big_q   <= 1'b0;
      small_q <= 1'b0;
    end else if (cls_en) begin
      big_q   <= exp_too_big && !zero_q;
      small_q <= exp_too_small || zero_q;
    end
  end

  // Step 4: pack.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else if (pack_en) begin
      ovf_q <= big_q;
      if (small_q)    result_q <= {sgn_q, {(W-1){1'b0}}};
      else if (big_q) result_q <= {sgn_q, EMAX_F, {FRAC_W{1'b1}}};
      else            result_q <= {sgn_q, enorm_q[EXP_W-1:0], frac_q};
    end
  end

  assign result_o = result_q;
  assign ovf_o    = ovf_q;

  // R9: a raised flag always comes with the saturated magnitude.
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (result_q[W-2:0] == {EMAX_F, {FRAC_W{1'b1}}}));

  // R10: an exponent below range at classification packs a zero magnitude.
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (pack_en && small_q) |=> (result_q[W-2:0] == '0 && !ovf_q));

  // R11: outside the pack step the output registers do not move.
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pack_en |=> ($stable(result_q) && $stable(ovf_q)));

endmodule

// File: rtl/fpmul_seq.sv
module fpmul_seq
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic [EXP_W+FRAC_W:0] product,
  output logic                  done,
  output logic                  overflow
);

  localparam int W = 1 + EXP_W + FRAC_W;

  fpm_state_e state;
  logic accept, mul_en, norm_en, cls_en, pack_en;

  fpm_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .state_o   (state),
    .accept_o  (accept),
    .mul_en_o  (mul_en),
    .norm_en_o (norm_en),
    .cls_en_o  (cls_en),
    .pack_en_o (pack_en),
    .done_o    (done)
  );

  fpm_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (accept),
    .mul_en   (mul_en),
    .norm_en  (norm_en),
    .cls_en   (cls_en),
    .pack_en  (pack_en),
    .op_a     (op_a),
    .op_b     (op_b),
    .result_o (product),
    .ovf_o    (overflow)
  );

  logic op_has_zero;
  assign op_has_zero = (op_a[W-2 -: EXP_W] == '0) || (op_b[W-2 -: EXP_W] == '0);

  // R5: done first appears exactly four edges after the accepting edge.
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(accept, 5));

  // R2: sign of the finished result follows the operands seen at acceptance.
  a_r2_sign: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(accept, 5)) |-> (product[W-1] == $past(op_a[W-1] ^ op_b[W-1], 5)));

  // R8: a zero operand at acceptance yields a zero magnitude without overflow.
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(accept && op_has_zero, 5)) |-> (product[W-2:0] == '0 && !overflow));

endmodule

// File: tb/sim_fpmul_seq.sv
module sim_fpmul_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] product;
  logic        done;
  logic        overflow;

  int n_cmp  = 0;
  int n_miss = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fpmul_seq u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_a     (op_a),
    .op_b     (op_b),
    .product  (product),
    .done     (done),
    .overflow (overflow)
  );

  // {op_a, op_b, expected product, expected overflow}
  localparam int NV = 17;
  localparam logic [96:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0}, // R3 1*1
    {32'h40000000, 32'h40400000, 32'h40C00000, 1'b0}, // R3 2*3
    {32'hBFC00000, 32'h40200000, 32'hC0700000, 1'b0}, // R2 -1.5*2.5
    {32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0}, // R4 normalize step
    {32'hC0400000, 32'hBF000000, 32'h3FC00000, 1'b0}, // R2 neg*neg
    {32'h00000000, 32'h40490FDB, 32'h00000000, 1'b0}, // R8
    {32'h80000000, 32'h3F800000, 32'h80000000, 1'b0}, // R8 signed zero
    {32'h3F800000, 32'h80000000, 32'h80000000, 1'b0}, // R8
    {32'h7F000000, 32'h40000000, 32'h7F7FFFFF, 1'b1}, // R9
    {32'hFF000000, 32'h40000000, 32'hFF7FFFFF, 1'b1}, // R9 negative
    {32'h7F000000, 32'h3F800000, 32'h7F000000, 1'b0}, // R9 edge, no flag
    {32'h7F400000, 32'h3FC00000, 32'h7F7FFFFF, 1'b1}, // R9 via normalize
    {32'h00800000, 32'h00800000, 32'h00000000, 1'b0}, // R10
    {32'h80800000, 32'h00800000, 32'h80000000, 1'b0}, // R10 signed
    {32'h20400000, 32'h1FC00000, 32'h00900000, 1'b0}, // R10 edge rescued by normalize
    {32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 1'b0}, // R3 truncation, bit47 set
    {32'h3F800001, 32'h3F800001, 32'h3F800002, 1'b0}  // R3 truncation, bit47 clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
    end
  endtask

  // Applies operands with start at a falling edge; counts rising edges until done.
  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
  endtask

  task automatic wait_done(inout int lat);
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done && lat < 20);
  endtask

  task automatic release_start(input string req);
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req, {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lat;
    logic [31:0] held;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 overflow", {31'd0, overflow}, 32'd0);
    check("R1 product", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {30'd0, done, overflow}, 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][96:65], VEC[i][64:33]);
      lat = 0;
      wait_done(lat);
      check("R5 latency", lat, 32'd5);
      check("R2/R3/R4/R8/R9/R10 product", product, VEC[i][32:1]);
      check("R9 overflow", {31'd0, overflow}, {31'd0, VEC[i][0]});
      held = product;
      repeat (3) begin
        @(posedge clk);
        @(negedge clk);
      end
      check("R6 done held", {31'd0, done}, 32'd1);
      check("R6 product held", product, held);
      release_start("R6 release");
      op_a = 32'h40490FDB;
      op_b = 32'hC0000000;
      repeat (2) @(negedge clk);
      check("R11 product after done", product, held);
      check("R6 no retrigger", {31'd0, done}, 32'd0);
    end

    // R7: operands change right after acceptance
    launch(32'h40000000, 32'h40400000);
    lat = 0;
    @(posedge clk);
    lat++;
    @(negedge clk);
    op_a = 32'h7F000000;
    op_b = 32'hC0800000;
    wait_done(lat);
    check("R7 latency", lat, 32'd5);
    check("R7 captured operands", product, 32'h40C00000);
    check("R7 no overflow", {31'd0, overflow}, 32'd0);
    release_start("R7 release");

    // R7: start pulsed for one cycle; the sequence still completes
    launch(32'hC0400000, 32'h40000000);
    lat = 0;
    @(posedge clk);
    lat++;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check("R7 pulse latency", lat, 32'd5);
    check("R7 pulse product", product, 32'hC0C00000);
    @(posedge clk);
    @(negedge clk);
    check("R6 pulse done falls", {31'd0, done}, 32'd0);
    check("R11 pulse held", product, 32'hC0C00000);

    summary();
  end

endmodule